// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small registered-output programmable logic device. Twelve dedicated inputs and ten feedback signals from the output cells are each offered to the array in true and complement form. The array evaluates a fixed set of product terms over those lines. Each product term is a wide AND, and a configuration bit at every crossing selects whether a line takes part. Ten fixed OR gates of unequal size combine the product terms into ten sums. Further dedicated product terms give one enable per output and two global controls: a synchronous preset and an asynchronous clear.

The configuration is held in registers. It is loaded one bit at a time over a valid/ready stream, and only while a program-mode pin is high. The stream's ready signal is simply the program-mode pin. A source may hold valid high as long as it likes while ready is low; no bit is consumed until both are high at a rising clock edge.

While programming is in progress, every array output is held low. Outside program mode, the path from the input pins to the sums and control terms is purely combinational. Dedicated input 0 is also brought out as the clock for the downstream output registers, and it stays a normal array input as well.

Top module: `pla_array`

## Requirements
- R1: The array sees 44 lines. Line 2s is the true value of source s and line 2s+1 is its complement. Sources 0 to 11 are `ded_in[0..11]` and sources 12 to 21 are `fb_in[0..9]`.
- R2: Product term t uses configuration bit t*44+l for line l, and a set bit means connected. Outside program mode, a term is 1 exactly when every connected line is 1.
- R3: A product term with both the true and the complement line of any one source connected is always 0, whatever the inputs.
- R4: A product term with no connected line is always 1 outside program mode.
- R5: Sum k is the OR of 8+2*min(k,9-k) consecutive product terms (sizes 8,10,12,14,16,16,14,12,10,8). The terms are numbered from 0 upward starting at sum 0, so terms 0 to 119 feed the sums.
- R6: Term 120+k drives `oe_term[k]`, term 130 drives `preset_term` and term 131 drives `clear_term`.
- R7: A configuration bit is taken on a rising clock edge when `cfg_valid` and `cfg_ready` are both high. Bits shift in MSB-first, so after 5808 accepted bits the first bit sent sits at index 5807.
- R8: `cfg_ready` equals `prog_en`. Bits offered while `prog_en` is low are not taken and leave the array's behaviour unchanged.
- R9: While `prog_en` is high, `sum_out`, `oe_term`, `preset_term` and `clear_term` are all 0.
- R10: Reset sets every configuration bit to 1 (all crossings connected), so every term and every sum is 0 after reset.
- R11: `mc_clk` follows `ded_in[0]`, and `ded_in[0]` still reaches the array as source 0.
- R12: Outside program mode, the outputs follow input changes within the same clock cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Program mode: allows loading and forces the outputs low |
| cfg_valid | input | 1 | Configuration bit offered |
| cfg_data | input | 1 | Configuration bit value (1 = connected) |
| cfg_ready | output | 1 | Configuration bit can be taken |
| ded_in | input | 12 | Dedicated inputs (bit 0 also clocks the output cells) |
| fb_in | input | 10 | Feedback from the ten output cells |
| sum_out | output | 10 | OR sums, one per output |
| oe_term | output | 10 | Output-enable product terms |
| preset_term | output | 1 | Global synchronous preset term |
| clear_term | output | 1 | Global asynchronous clear term |
| mc_clk | output | 1 | Clock for the output registers, taken from `ded_in[0]` |

## Verification
The bench builds the block with its default parameters: 12 dedicated inputs, 10 feedbacks, and sums of 8 to 16 terms. This brings the full 5808-bit chain into reach, along with both the narrowest and widest sums and their boundaries. With these values, a sum-offset or term-numbering slip shows up as a wrong sum, and an off-by-one in the shift chain shows up on the last control terms. Random sparse configurations exercise realistic product terms. A directed configuration pins each sum to one known term and ties each control term to a single pin.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Terms feeding sum k: grows by step toward the middle, symmetric about it
  function automatic int sum_size(int k, int n_out, int base, int step);
    int m;
    m = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
    return base + step * m;
  endfunction

  // Index of the first term feeding sum k
  function automatic int sum_offset(int k, int n_out, int base, int step);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += sum_size(j, n_out, base, step);
    return acc;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int W = 5808
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prog_en,
  input  logic         cfg_valid,
  input  logic         cfg_data,
  output logic         cfg_ready,
  output logic [W-1:0] cfg_q
);
  logic take;

  assign cfg_ready = prog_en;
  assign take      = cfg_valid & prog_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '1;
    else if (take) cfg_q <= {cfg_q[W-2:0], cfg_data};
  end

  assert_shift_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready) |=> (cfg_q[0] == $past(cfg_data)) && (cfg_q[W-1:1] == $past(cfg_q[W-2:0])));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && prog_en) |=> $stable(cfg_q));

endmodule

// File: rtl/pla_pterm.sv
module pla_pterm #(
  parameter int N_LINE = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [N_LINE-1:0] lines,
  input  logic [N_LINE-1:0] mask,
  output logic              term
);
  localparam int N_PAIR = N_LINE / 2;

  logic [N_PAIR-1:0] pair_both;

  assign term = !hold && (&(lines | ~mask));

  for (genvar s = 0; s < N_PAIR; s++) begin : g_pair
    assign pair_both[s] = mask[2*s] & mask[2*s+1];
  end

  assert_conflict_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pair_both) |-> !term);

  assert_empty_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (mask == '0)) |-> term);

endmodule

// File: rtl/pla_or_tree.sv
module pla_or_tree #(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0] terms,
  output logic            any
);
  assign any = |terms;
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_DED      = 12,
  parameter int N_FB       = 10,
  parameter int BASE_TERMS = 8,
  parameter int STEP_TERMS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_en,
  input  logic            cfg_valid,
  input  logic            cfg_data,
  output logic            cfg_ready,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_FB-1:0]  fb_in,
  output logic [N_FB-1:0]  sum_out,
  output logic [N_FB-1:0]  oe_term,
  output logic            preset_term,
  output logic            clear_term,
  output logic            mc_clk
);
  localparam int N_SRC    = N_DED + N_FB;
  localparam int N_LINE   = 2 * N_SRC;
  localparam int N_SUMT   = pla_pkg::sum_offset(N_FB, N_FB, BASE_TERMS, STEP_TERMS);
  localparam int OE_BASE  = N_SUMT;
  localparam int PRE_IDX  = N_SUMT + N_FB;
  localparam int CLR_IDX  = PRE_IDX + 1;
  localparam int N_TERM   = CLR_IDX + 1;
  localparam int CFG_BITS = N_TERM * N_LINE;

  logic [CFG_BITS-1:0] cfg_q;
  logic [N_SRC-1:0]    src;
  logic [N_LINE-1:0]   lines;
  logic [N_TERM-1:0]   pterm;

  pla_cfg_chain #(.W(CFG_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .cfg_ready(cfg_ready), .cfg_q(cfg_q)
  );

  assign src    = {fb_in, ded_in};
  assign mc_clk = ded_in[0];

  for (genvar s = 0; s < N_SRC; s++) begin : g_line
    assign lines[2*s]   = src[s];
    assign lines[2*s+1] = ~src[s];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pla_pterm #(.N_LINE(N_LINE)) u_pt (
      .clk(clk), .rst_n(rst_n), .hold(prog_en),
      .lines(lines), .mask(cfg_q[t*N_LINE +: N_LINE]),
      .term(pterm[t])
    );
  end

  for (genvar k = 0; k < N_FB; k++) begin : g_sum
    localparam int OFF = pla_pkg::sum_offset(k, N_FB, BASE_TERMS, STEP_TERMS);
    localparam int SZ  = pla_pkg::sum_size(k, N_FB, BASE_TERMS, STEP_TERMS);
    pla_or_tree #(.N_IN(SZ)) u_or (
      .terms(pterm[OFF +: SZ]),
      .any(sum_out[k])
    );
  end

  assign oe_term     = pterm[OE_BASE +: N_FB];
  assign preset_term = pterm[PRE_IDX];
  assign clear_term  = pterm[CLR_IDX];

  assert_quiet_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (sum_out == '0) && (oe_term == '0) && !preset_term && !clear_term);

endmodule

// File: tb/pla_array_tb.sv
module pla_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 22;
  localparam int NL = 44;
  localparam int NT = 132;
  localparam int CB = NT * NL;

  logic clk = 0;
  logic rst_n = 0;
  logic prog_en = 0, cfg_valid = 0, cfg_data = 0;
  logic cfg_ready;
  logic [11:0] ded_in = '0;
  logic [9:0]  fb_in = '0;
  logic [9:0]  sum_out, oe_term;
  logic preset_term, clear_term, mc_clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [CB-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .cfg_ready(cfg_ready), .ded_in(ded_in), .fb_in(fb_in),
    .sum_out(sum_out), .oe_term(oe_term), .preset_term(preset_term),
    .clear_term(clear_term), .mc_clk(mc_clk)
  );

  function automatic int size_of(int k);
    return 8 + 2 * ((k < 9 - k) ? k : 9 - k);
  endfunction

  function automatic logic [21:0] expect_out(logic [21:0] s);
    logic [NT-1:0] tv;
    logic [9:0] sm;
    int base;
    for (int t = 0; t < NT; t++) begin
      tv[t] = 1'b1;
      for (int l = 0; l < NL; l++)
        if (model[t*NL+l]) tv[t] &= (l % 2 == 1) ? ~s[l/2] : s[l/2];
    end
    base = 0;
    for (int k = 0; k < 10; k++) begin
      sm[k] = 1'b0;
      for (int j = 0; j < size_of(k); j++) sm[k] |= tv[base+j];
      base += size_of(k);
    end
    return {sm, tv[129:120], tv[130], tv[131]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_rand();
    ded_in = 12'($urandom);
    fb_in  = 10'($urandom);
    #2;
  endtask

  task automatic check_model(string tag);
    check(tag, {10'd0, sum_out, oe_term, preset_term, clear_term},
          {10'd0, expect_out({fb_in, ded_in})});
  endtask

  task automatic load_cfg(logic [CB-1:0] c);
    @(negedge clk);
    prog_en = 1;
    for (int i = CB - 1; i >= 0; i--) begin
      if ($urandom % 8 == 0) begin
        cfg_valid = 0;
        cfg_data  = 1'($urandom);
        @(negedge clk);
      end
      cfg_valid = 1;
      cfg_data  = c[i];
      if (i == CB - 100) begin
        drive_rand();
        check("R9 outputs low in program mode",
              {10'd0, sum_out, oe_term, preset_term, clear_term}, 32'd0);
        check("R8 ready in program mode", {31'd0, cfg_ready}, 32'd1);
      end
      @(negedge clk);
    end
    cfg_valid = 0;
    prog_en   = 0;
    model     = c;
    #1;
  endtask

  task automatic t_reset();
    for (int v = 0; v < 4; v++) begin
      drive_rand();
      check("R10 reset state all low",
            {10'd0, sum_out, oe_term, preset_term, clear_term}, 32'd0);
    end
  endtask

  task automatic t_directed();
    logic [CB-1:0] c;
    int base;
    c = '0;
    base = 0;
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < size_of(k); j++) begin
        int t;
        t = base + j;
        if (k == 1 && j == 0) begin
          // left empty: always true
        end else if (k >= 2 && j == size_of(k) - 1) begin
          c[t*NL + 2*k] = 1'b1;
        end else begin
          c[t*NL + 2*(t % NS)]     = 1'b1;
          c[t*NL + 2*(t % NS) + 1] = 1'b1;
        end
      end
      base += size_of(k);
    end
    for (int k = 0; k < 10; k++) c[(120+k)*NL + 2*(12+k) + 1] = 1'b1;
    c[130*NL + 0] = 1'b1;
    load_cfg(c);
    for (int v = 0; v < 12; v++) begin
      drive_rand();
      check("R3 conflicting terms keep sum 0 low", {31'd0, sum_out[0]}, 32'd0);
      check("R4 empty term drives sum 1 high", {31'd0, sum_out[1]}, 32'd1);
      check("R5 last term of each sum lands in place", {22'd0, sum_out[9:2]}, {22'd0, ded_in[9:2]});
      check("R1 R6 enable terms see feedback complement", {22'd0, oe_term}, {22'd0, ~fb_in});
      check("R11 preset term sees input 0", {31'd0, preset_term}, {31'd0, ded_in[0]});
      check("R11 clock pin follows input 0", {31'd0, mc_clk}, {31'd0, ded_in[0]});
      check("R6 empty clear term high", {31'd0, clear_term}, 32'd1);
      check_model("R2 directed model");
    end
  endtask

  task automatic t_ignore();
    @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      cfg_valid = 1;
      cfg_data  = 1'($urandom);
      if (i == 5) check("R8 ready low outside program mode", {31'd0, cfg_ready}, 32'd0);
      @(negedge clk);
    end
    cfg_valid = 0;
    for (int v = 0; v < 6; v++) begin
      drive_rand();
      check_model("R8 offered bits ignored");
    end
  endtask

  task automatic t_random(int rounds);
    for (int r = 0; r < rounds; r++) begin
      logic [CB-1:0] c;
      for (int i = 0; i < CB; i++) c[i] = ($urandom % 20 == 0);
      load_cfg(c);
      for (int v = 0; v < 15; v++) begin
        @(negedge clk);
        drive_rand();
        check_model("R2 R5 R6 R7 random config");
        drive_rand();
        check_model("R12 change without clock edge");
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    model = '1;
    #(CLK_PERIOD * 3);
    rst_n = 1;
    t_reset();
    t_directed();
    t_ignore();
    t_random(4);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule